// File: doc/BRIEF.md
# Droplet Reservoir LED Controller

This block animates a 16-LED bar as a water tank. A drop appears at a fixed entry position (LED 14) on a regular cadence, falls one LED per movement tick, and comes to rest on top of the drops already collected. Once LED 0 through LED 14 are lit the tank is full. New drops stop, and the entry LED blinks while the block waits for an operator to unlock the drain.

Three designated switches (2, 8 and 13) unlock the drain. Each must have been seen ON at least once since reset. They need not be ON together, and a switch flipped during filling also counts. When the unlock is complete, the lit column empties from the top down, one LED per movement tick. When the last LED goes out the block stops in a terminal state until reset. The outputs are the LED vector and three plain status pins for a neighbouring display block. The block has no data stream, so it has no valid/ready interface. Every pin is plain control or status, and no back-pressure applies. Reset is synchronous and active high.

Top module: `droplet_reservoir`

## Requirements
- R1: While reset is held and on the first sample after it, all LEDs are dark and `full`, `draining` and `done` are 0.
- R2: On the first movement tick after reset, and then on every 4th movement tick while filling, a new drop is lit at LED 14. The divider's first tick comes MOVE_DIV cycles after reset is released.
- R3: A falling drop moves down by exactly one LED position on each movement tick.
- R4: A drop that reaches the position just above the highest resting drop (LED 0 when none rest) stops there and joins the resting column on the next tick. LED 15 is never lit.
- R5: When LEDs 0 to 14 all rest lit, `full` goes to 1 one cycle after the tick that completed the column, and no further drop is injected.
- R6: While `full` is 1, LEDs 0 to 13 stay lit. LED 14 is lit for the first BLINK_HALF_DIV cycles in the full state and then toggles every BLINK_HALF_DIV cycles.
- R7: Each unlock switch (bit 2, 8, 13 of `sw`) is remembered once seen ON. The full state holds until all three have been seen, in any order or at different times. The other switch bits have no effect.
- R8: If all three unlock switches were seen before the column completed, `draining` is 1 two cycles after the completing tick.
- R9: While `draining` is 1, each movement tick turns off the topmost lit LED. The lit LEDs always form a contiguous run starting at LED 0.
- R10: One cycle after the tick that turns off the last LED, `done` is 1 and `draining` is 0. The LEDs stay dark and `done` stays 1 until reset.
- R11: Reset clears the remembered unlock switches, so a later fill waits in the full state again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (100 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| sw | input | 16 | Switch levels; bits 2, 8 and 13 unlock the drain |
| led | output | 16 | LED bar, bit i drives LED i |
| full | output | 1 | Tank full, waiting for unlock |
| draining | output | 1 | Tank emptying |
| done | output | 1 | Tank empty, sequence finished |

## Verification
The assertions check properties that hold on every cycle:
- LED 15 stays dark.
- At most one status flag is high.
- The lit count never falls while filling.
- The lit count falls by no more than one per cycle while draining.
- LEDs 0 to 13 stay lit while full.
- The terminal state persists.

Only the bench scenarios can show the following:
- The exact tick-by-tick position of every falling drop, and the blink phase timing.
- That a partial unlock leaves the tank full.
- That an unlock completed during filling starts the drain at once.
- That reset forgets previously seen switches.

// File: rtl/droplet_pkg.sv
package droplet_pkg;
  typedef enum logic [1:0] {
    ST_FILL  = 2'd0,
    ST_FULL  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } res_state_e;
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int DIV = 33_333_333,
  localparam int W = $clog2(DIV + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  logic [W-1:0] cnt_q;

  assign tick = (cnt_q == W'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/unlock_tracker.sv
module unlock_tracker #(
  parameter int          N_SW = 16,
  parameter logic [15:0] MASK = 16'h2104
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_SW-1:0] sw,
  output logic            all_seen
);
  logic [N_SW-1:0] seen_q;
  logic [N_SW-1:0] mask_w;

  assign mask_w   = N_SW'(MASK);
  assign all_seen = &(seen_q | ~mask_w);

  always_ff @(posedge clk) begin
    if (rst) seen_q <= '0;
    else     seen_q <= seen_q | (sw & mask_w);
  end
endmodule

// File: rtl/drop_column.sv
module drop_column #(
  parameter int N_LED      = 16,
  parameter int ENTRY_IDX  = 14,
  parameter int DROP_TICKS = 4,
  localparam int LW = $clog2(N_LED + 1),
  localparam int CW = $clog2(DROP_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             fill_en,
  input  logic             drain_en,
  output logic [LW-1:0]    level,
  output logic [N_LED-1:0] mask
);
  localparam int FULL_LEVEL = ENTRY_IDX + 1;

  logic [LW-1:0]    lvl_q, lvl_d;
  logic [N_LED-1:0] fall_q, fall_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [N_LED-1:0] at_top;
  logic [N_LED-1:0] settled;
  logic             hit;

  for (genvar i = 0; i < N_LED; i++) begin : g_pos
    assign at_top[i]  = (LW'(i) == lvl_q);
    assign settled[i] = (LW'(i) < lvl_q);
  end

  assign hit   = |(fall_q & at_top);
  assign level = lvl_q;
  assign mask  = settled | fall_q;

  always_comb begin
    lvl_d  = lvl_q;
    fall_d = fall_q;
    cnt_d  = cnt_q;
    if (tick && fill_en) begin
      fall_d = (fall_q & ~at_top) >> 1;
      lvl_d  = lvl_q + LW'(hit);
      if (cnt_q == '0 && lvl_d < LW'(FULL_LEVEL)) fall_d[ENTRY_IDX] = 1'b1;
      cnt_d = (cnt_q == CW'(DROP_TICKS - 1)) ? '0 : cnt_q + 1'b1;
    end else if (tick && drain_en && lvl_q != '0) begin
      lvl_d = lvl_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= '0;
      fall_q <= '0;
      cnt_q  <= '0;
    end else begin
      lvl_q  <= lvl_d;
      fall_q <= fall_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/droplet_reservoir.sv
module droplet_reservoir
  import droplet_pkg::*;
#(
  parameter int          N_LED          = 16,
  parameter int          ENTRY_IDX      = 14,
  parameter int          DROP_TICKS     = 4,
  parameter int          MOVE_DIV       = 33_333_333,
  parameter int          BLINK_HALF_DIV = 33_333_333,
  parameter logic [15:0] UNLOCK_MASK    = 16'h2104
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_LED-1:0] sw,
  output logic [N_LED-1:0] led,
  output logic             full,
  output logic             draining,
  output logic             done
);
  localparam int LW         = $clog2(N_LED + 1);
  localparam int FULL_LEVEL = ENTRY_IDX + 1;

  res_state_e       state_q, state_d;
  logic             move_tick, blink_tick;
  logic             all_seen;
  logic             blink_q;
  logic [LW-1:0]    col_level;
  logic [N_LED-1:0] col_mask;

  tick_divider #(.DIV(MOVE_DIV)) u_move_div (
    .clk(clk), .rst(rst), .clr(1'b0), .tick(move_tick)
  );

  tick_divider #(.DIV(BLINK_HALF_DIV)) u_blink_div (
    .clk(clk), .rst(rst), .clr(state_q != ST_FULL), .tick(blink_tick)
  );

  unlock_tracker #(.N_SW(N_LED), .MASK(UNLOCK_MASK)) u_unlock (
    .clk(clk), .rst(rst), .sw(sw), .all_seen(all_seen)
  );

  drop_column #(
    .N_LED(N_LED), .ENTRY_IDX(ENTRY_IDX), .DROP_TICKS(DROP_TICKS)
  ) u_column (
    .clk     (clk),
    .rst     (rst),
    .tick    (move_tick),
    .fill_en (state_q == ST_FILL),
    .drain_en(state_q == ST_DRAIN),
    .level   (col_level),
    .mask    (col_mask)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FILL:  if (col_level == LW'(FULL_LEVEL)) state_d = ST_FULL;
      ST_FULL:  if (all_seen) state_d = ST_DRAIN;
      ST_DRAIN: if (col_level == '0) state_d = ST_DONE;
      default:  state_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FILL;
      blink_q <= 1'b1;
    end else begin
      state_q <= state_d;
      if (state_q != ST_FULL) blink_q <= 1'b1;
      else if (blink_tick)    blink_q <= ~blink_q;
    end
  end

  always_comb begin
    led = col_mask;
    if (state_q == ST_FULL) led[ENTRY_IDX] = blink_q;
  end

  assign full     = (state_q == ST_FULL);
  assign draining = (state_q == ST_DRAIN);
  assign done     = (state_q == ST_DONE);
endmodule

// File: rtl/droplet_reservoir_chk.sv
module droplet_reservoir_chk #(
  parameter int N_LED = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [N_LED-1:0] led,
  input logic             full,
  input logic             draining,
  input logic             done
);
  logic filling;
  assign filling = !full && !draining && !done;

  p_top_dark_r4: assert property (@(posedge clk) disable iff (rst)
    !led[N_LED-1]);

  p_flags_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({full, draining, done}));

  p_full_steady_r6: assert property (@(posedge clk) disable iff (rst)
    full |-> (&led[N_LED-3:0]));

  p_fill_grows_r2: assert property (@(posedge clk) disable iff (rst)
    (filling && $past(filling)) |->
      ($countones(led) >= $countones($past(led))));

  p_drain_step_r9: assert property (@(posedge clk) disable iff (rst)
    (draining && $past(draining)) |->
      (($countones(led) == $countones($past(led))) ||
       ($countones(led) + 1 == $countones($past(led)))));

  p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && led == '0));
endmodule

bind droplet_reservoir droplet_reservoir_chk #(.N_LED(N_LED)) u_chk (
  .clk(clk), .rst(rst), .led(led), .full(full),
  .draining(draining), .done(done)
);

// File: tb/test_droplet_reservoir.sv
module test_droplet_reservoir;
  localparam int DIV  = 8;
  localparam int H    = 12;
  localparam logic [15:0] UMASK = 16'h2104;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] sw  = '0;
  logic [15:0] led;
  logic        full, draining, done;
  int          cyc = 0;
  int          checks = 0;
  int          fails = 0;
  bit          finished = 0;

  droplet_reservoir #(
    .MOVE_DIV(DIV), .BLINK_HALF_DIV(H)
  ) i_droplet_reservoir (
    .clk(clk), .rst(rst), .sw(sw), .led(led),
    .full(full), .draining(draining), .done(done)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cyc=%0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic wait_cyc(input int target);
    while (cyc != target) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    sw  = '0;
    repeat (3) @(negedge clk);
    chk("R1 led in reset", led, 16'h0);
    chk("R1 flags in reset", {full, draining, done}, 3'b000);
    rst = 1'b0;
  endtask

  // Expected column after n movement ticks of filling.
  function automatic void model_fill(input int n, output logic [15:0] lmask, output int lvl);
    int          lv;
    int          c;
    logic [15:0] f;
    logic [15:0] top;
    bit          hit;
    lv = 0; c = 0; f = '0;
    for (int t = 1; t <= n; t++) begin
      if (lv < 15) begin
        top = 16'h1 << lv;
        hit = |(f & top);
        f   = (f & ~top) >> 1;
        if (hit) lv++;
        if (c == 0 && lv < 15) f[14] = 1'b1;
        c = (c + 1) % 4;
      end
    end
    lmask = 16'((32'h1 << lv) - 1) | f;
    lvl   = lv;
  endfunction

  // Runs the fill; unlock_early selects the scenario. Returns the completing tick.
  task automatic run_fill(input bit unlock_early, output int full_tick);
    logic [15:0] exp;
    int          lvl;
    logic [15:0] decoy;
    full_tick = 0;
    for (int n = 1; n < 200; n++) begin
      wait_cyc(n * DIV + 2);
      model_fill(n, exp, lvl);
      if (lvl >= 15) begin
        full_tick = n;
        break;
      end
      chk("R3 falling/settled pattern", led, exp);
      chk("R5 not full while filling", {full, draining}, 2'b00);
      if (n == 1) chk("R2 first drop at LED14", led, 16'h4000);
      if (led[15]) chk("R4 LED15 dark", {31'd0, led[15]}, 32'd0);
      decoy = 16'($urandom) & ~UMASK;
      if (unlock_early) begin
        if (n == 6)  decoy[2]  = 1'b1;
        if (n == 20) decoy[8]  = 1'b1;
        if (n == 35) decoy[13] = 1'b1;
      end
      sw = decoy;
    end
    sw = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int ft;
    int f0;
    int lit;
    int t;
    void'($urandom(32'd4242));

    // Scenario A: unlock switches seen during filling.
    do_reset();
    run_fill(1'b1, ft);
    chk("R5 fill completes", (ft > 0) ? 32'd1 : 32'd0, 32'd1);
    chk("R8 early unlock drains at once", {full, draining, done}, 3'b010);
    chk("R8 column intact at drain start", led, 16'h7FFF);

    // Scenario B: reset must forget those switches.
    do_reset();
    chk("R11 post-reset led", led, 16'h0);
    run_fill(1'b0, ft);
    chk("R11 full holds after reset clears switches", {full, draining, done}, 3'b100);
    chk("R5 full column", led, 16'h7FFF);

    f0 = ft * DIV + 1;
    for (int k = 0; k < 6; k++) begin
      wait_cyc(f0 + k * H + H / 2);
      sw = 16'($urandom) & ~UMASK;
      chk("R6 entry LED blink phase", {31'd0, led[14]}, (k % 2 == 0) ? 32'd1 : 32'd0);
      chk("R6 lower LEDs steady", {18'd0, led[13:0]}, 32'h3FFF);
    end

    // Partial unlock: switches 2 and 8 at different times.
    @(negedge clk); sw = 16'h0004;
    @(negedge clk); sw = 16'h0000;
    repeat (5) @(negedge clk); sw = 16'h0100;
    @(negedge clk); sw = 16'h0000;
    repeat (20) @(negedge clk);
    chk("R7 two of three switches keep full", {full, draining}, 2'b10);
    sw = 16'hDEFB & ~UMASK;
    repeat (10) @(negedge clk);
    chk("R7 decoy switches ignored", {full, draining}, 2'b10);
    sw = 16'h2000;
    @(negedge clk); sw = 16'h0000;
    @(negedge clk);
    chk("R7 third switch starts drain", {full, draining, done}, 3'b010);
    chk("R9 drain starts with full column", led, 16'h7FFF);

    lit = 15;
    while (lit > 0) begin
      t = (cyc / DIV + 1) * DIV;
      wait_cyc(t + 1);
      lit--;
      chk("R9 topmost LED removed", led, 16'((32'h1 << lit) - 1));
      if (lit > 0) chk("R9 draining flag", {full, draining, done}, 3'b010);
    end
    chk("R10 done after last LED", {full, draining, done}, 3'b001);
    for (int k = 0; k < 3; k++) begin
      sw = 16'($urandom);
      repeat (DIV) @(negedge clk);
      chk("R10 stays done and dark", {led, full, draining, done}, {16'h0, 3'b001});
    end

    finish_run();
  end
endmodule